// File: doc/BRIEF.md
# Flash Programming Port Command Controller

This block sits between a byte-wide parallel programming port and an on-chip flash array. It watches three active-low strobes (chip enable, output enable, write enable), an 18-bit address and an 8-bit data bus. From the writes it decodes multi-cycle command sequences for four operations: array read, page program, whole-array erase and status inspection. Array, page buffer and status byte are modelled behaviourally. The time a program or erase takes is modelled by a busy counter of `BUSY_CYCLES` clocks.

Writes are taken on the rising edge of write enable while chip enable is low. The edge is found by a synchroniser and edge detector running on the system clock. The address and data travel through the same synchroniser stages, so they arrive aligned with the edge. Reads are combinational from the port pins: the data-out enable follows the strobes, and the value driven depends on the controller state.

The controller states are:

| State | Meaning |
|-------|---------|
| ST_READ | The array is readable. This is the state after reset. |
| ST_WAIT | Command wait. |
| ST_STAT | Reads return the status byte. |
| ST_ERS_CONF | Waiting for the second erase cycle. |
| ST_STS_CONF | Waiting for the second status cycle. |
| ST_PRG_LOAD | Collecting the 128 bytes of a page program. |
| ST_PRG_BUSY | A page program is running. |
| ST_ERS_BUSY | An erase is running. |

The transitions are:

- **From ST_READ, ST_WAIT or ST_STAT**, a write of H'00 goes to ST_READ.
- **From the same three states**, H'40 goes to ST_PRG_LOAD, H'20 goes to ST_ERS_CONF, and H'71 goes to ST_STS_CONF. Any other code goes to ST_WAIT with the error flag set.
- **ST_ERS_CONF** goes to ST_ERS_BUSY on a second H'20. Any other value goes to ST_WAIT with an error.
- **ST_STS_CONF** goes to ST_STAT on a second H'71. Any other value goes to ST_WAIT with an error.
- **ST_PRG_LOAD** goes to ST_PRG_BUSY after the 128th write. It goes to ST_WAIT with an error on an off-page address.
- **ST_PRG_BUSY and ST_ERS_BUSY** go to ST_WAIT when the busy count expires.

Top module: `fpm_ctrl`

## Requirements
- R1: After reset the controller is in array read mode and every array byte reads H'FF.
- R2: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other strobe combination it is 0, which means the bus is high-impedance.
- R3: In array read mode any sequence of back-to-back reads returns the array byte at the low `log2(MEM_BYTES)` bits of `addr`.
- R4: In command wait, and while a command sequence is still incomplete, reads drive H'00. Array data becomes visible again only after an H'00 command write.
- R5: H'40 followed by 128 writes to one 128-byte page (page = `addr[17:7]`, offset = `addr[6:0]`) stores each data byte at its offset. The page is committed to the array when the busy period ends, and the controller then enters command wait.
- R6: During a program or erase, reads return the status byte with bit 7 (busy) set, for `BUSY_CYCLES` clocks. Writes made during that period are ignored.
- R7: H'20 followed by H'20 sets every array byte to H'FF when the busy period ends.
- R8: H'71 followed by H'71 enters status mode. In status mode reads return the status byte: bit 7 is busy, bit 6 is error, and the other bits are 0.
- R9: If the second cycle of an erase or status command differs from the first, the error bit is set, the controller enters command wait and the array is unchanged. The error bit is cleared when an H'40 command or a confirmed erase is accepted.
- R10: During a page program, a write whose page differs from the first write's page sets the error bit and returns to command wait, leaving the array unchanged.
- R11: A program or erase in progress completes while `ce_n` is held high.
- R12: A write strobe given while `ce_n` is high has no effect.
- R13: A command write with any code other than the four listed sets the error bit and enters command wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| addr | input | 18 | Byte address |
| din | input | 8 | Write data / command code |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The hardest condition to reach from the ports is a busy period overlapped with other port activity. The bench must read status and issue a stray command inside the `BUSY_CYCLES` window, and in a separate run hold chip enable high across the whole erase. The stimulus reaches these cases by timing: a read is issued immediately after the 128th page write is taken, a write follows inside the window, and the result is inspected only after the window has closed. The off-page program is reached by changing page on the second load write. Its error is then confirmed through a status read, and the array contents are confirmed through reads after re-entering read mode.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_STATUS = 8'h71;

    localparam int STAT_BUSY_BIT = 7;
    localparam int STAT_ERR_BIT  = 6;

    typedef enum logic [2:0] {
        ST_READ,
        ST_WAIT,
        ST_STAT,
        ST_ERS_CONF,
        ST_STS_CONF,
        ST_PRG_LOAD,
        ST_PRG_BUSY,
        ST_ERS_BUSY
    } fpm_state_e;

endpackage

// File: rtl/fpm_bus_sync.sv
module fpm_bus_sync #(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    // Layout of one stage: {we_n, ce_n, addr, din}.
    localparam int W = ADDR_W + DATA_W + 2;
    localparam logic [W-1:0] IDLE = {2'b11, {(W-2){1'b0}}};

    logic [W-1:0] stg [SYNC_DEPTH];
    logic         we_last;
    logic [W-1:0] tail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_DEPTH; i++) stg[i] <= IDLE;
            we_last <= 1'b1;
        end else begin
            stg[0] <= {we_n, ce_n, addr, din};
            for (int i = 1; i < SYNC_DEPTH; i++) stg[i] <= stg[i-1];
            we_last <= stg[SYNC_DEPTH-1][W-1];
        end
    end

    assign tail    = stg[SYNC_DEPTH-1];
    assign wr_stb  = tail[W-1] & ~we_last & ~tail[W-2];
    assign wr_addr = tail[W-3 -: ADDR_W];
    assign wr_data = tail[DATA_W-1:0];

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 128,
    parameter int BUSY_CYCLES = 1000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int MEM_AW     = $clog2(MEM_BYTES),
    localparam int PG_W       = MEM_AW - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output fpm_state_e        state,
    output logic [7:0]        status,
    output logic              buf_clear,
    output logic              buf_wr,
    output logic [OFF_W-1:0]  buf_off,
    output logic [7:0]        buf_data,
    output logic              commit,
    output logic [PG_W-1:0]   commit_page,
    output logic              erase_all
);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [OFF_W:0] LAST_WR = (OFF_W+1)'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    fpm_state_e        state_q, state_d;
    logic              err_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [OFF_W:0]    wc_q;
    logic [TAG_W-1:0]  page_q;
    logic              have_page_q;

    logic err_set, err_clr, cnt_load, wc_clr, wc_inc, pg_load, load_ok;
    logic [TAG_W-1:0] page_in;
    logic busy;

    assign page_in = wr_addr[ADDR_W-1:OFF_W];
    assign busy    = (state_q == ST_PRG_BUSY) || (state_q == ST_ERS_BUSY);
    assign load_ok = !have_page_q || (page_in == page_q);

    // Next-state and sequencing decisions.
    always_comb begin
        state_d  = state_q;
        err_set  = 1'b0;
        err_clr  = 1'b0;
        cnt_load = 1'b0;
        wc_clr   = 1'b0;
        wc_inc   = 1'b0;
        pg_load  = 1'b0;
        unique case (state_q)
            ST_READ, ST_WAIT, ST_STAT: begin
                if (wr_stb) begin
                    case (wr_data)
                        CMD_READ:   state_d = ST_READ;
                        CMD_PROG: begin
                            state_d = ST_PRG_LOAD;
                            err_clr = 1'b1;
                            wc_clr  = 1'b1;
                        end
                        CMD_ERASE:  state_d = ST_ERS_CONF;
                        CMD_STATUS: state_d = ST_STS_CONF;
                        default: begin
                            state_d = ST_WAIT;
                            err_set = 1'b1;
                        end
                    endcase
                end
            end
            ST_ERS_CONF: begin
                if (wr_stb) begin
                    if (wr_data == CMD_ERASE) begin
                        state_d  = ST_ERS_BUSY;
                        err_clr  = 1'b1;
                        cnt_load = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                        err_set = 1'b1;
                    end
                end
            end
            ST_STS_CONF: begin
                if (wr_stb) begin
                    if (wr_data == CMD_STATUS) begin
                        state_d = ST_STAT;
                    end else begin
                        state_d = ST_WAIT;
                        err_set = 1'b1;
                    end
                end
            end
            ST_PRG_LOAD: begin
                if (wr_stb) begin
                    if (!load_ok) begin
                        state_d = ST_WAIT;
                        err_set = 1'b1;
                    end else begin
                        wc_inc  = 1'b1;
                        pg_load = !have_page_q;
                        if (wc_q == LAST_WR) begin
                            state_d  = ST_PRG_BUSY;
                            cnt_load = 1'b1;
                        end
                    end
                end
            end
            ST_PRG_BUSY, ST_ERS_BUSY: begin
                if (cnt_q == '0) state_d = ST_WAIT;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // State register and sequencing registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_READ;
            err_q       <= 1'b0;
            cnt_q       <= '0;
            wc_q        <= '0;
            page_q      <= '0;
            have_page_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (err_clr)      err_q <= 1'b0;
            else if (err_set) err_q <= 1'b1;
            if (cnt_load)                 cnt_q <= CNT_LOAD;
            else if (busy && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (wc_clr) begin
                wc_q        <= '0;
                have_page_q <= 1'b0;
            end else if (wc_inc) begin
                wc_q <= wc_q + 1'b1;
            end
            if (pg_load) begin
                page_q      <= page_in;
                have_page_q <= 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        state       = state_q;
        status      = '0;
        status[STAT_BUSY_BIT] = busy;
        status[STAT_ERR_BIT]  = err_q;
        buf_clear   = wc_clr;
        buf_wr      = wc_inc;
        buf_off     = wr_addr[OFF_W-1:0];
        buf_data    = wr_data;
        commit      = (state_q == ST_PRG_BUSY) && (cnt_q == '0);
        erase_all   = (state_q == ST_ERS_BUSY) && (cnt_q == '0);
        commit_page = page_q[PG_W-1:0];
    end

endmodule

// File: rtl/fpm_array.sv
module fpm_array #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 128,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int MEM_AW    = $clog2(MEM_BYTES),
    localparam int PG_W      = MEM_AW - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clear,
    input  logic              buf_wr,
    input  logic [OFF_W-1:0]  buf_off,
    input  logic [7:0]        buf_data,
    input  logic              commit,
    input  logic [PG_W-1:0]   commit_page,
    input  logic              erase_all,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_data
);
    logic [7:0] mem  [MEM_BYTES];
    logic [7:0] pbuf [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
        end else if (buf_clear) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
        end else if (buf_wr) begin
            pbuf[buf_off] <= buf_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (erase_all) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                mem[{commit_page, OFF_W'(i)}] <= pbuf[i];
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 128,
    parameter int BUSY_CYCLES = 1000,
    parameter int SYNC_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int MEM_AW = $clog2(MEM_BYTES);
    localparam int PG_W   = MEM_AW - OFF_W;

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    fpm_state_e        seq_state;
    logic [7:0]        status_byte;
    logic              buf_clear, buf_wr, commit_pulse, erase_all;
    logic [OFF_W-1:0]  buf_off;
    logic [7:0]        buf_data;
    logic [PG_W-1:0]   commit_page;
    logic [7:0]        rd_data;

    fpm_bus_sync #(
        .ADDR_W(ADDR_W), .DATA_W(8), .SYNC_DEPTH(SYNC_DEPTH)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .din(din),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fpm_seq #(
        .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES),
        .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .state(seq_state), .status(status_byte),
        .buf_clear(buf_clear), .buf_wr(buf_wr),
        .buf_off(buf_off), .buf_data(buf_data),
        .commit(commit_pulse), .commit_page(commit_page),
        .erase_all(erase_all)
    );

    fpm_array #(
        .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .buf_clear(buf_clear), .buf_wr(buf_wr),
        .buf_off(buf_off), .buf_data(buf_data),
        .commit(commit_pulse), .commit_page(commit_page),
        .erase_all(erase_all),
        .rd_idx(addr[MEM_AW-1:0]), .rd_data(rd_data)
    );

    assign dout_en = !ce_n && !oe_n && we_n;

    always_comb begin
        unique case (seq_state)
            ST_READ:                          dout = rd_data;
            ST_STAT, ST_PRG_BUSY, ST_ERS_BUSY: dout = status_byte;
            default:                          dout = 8'h00;
        endcase
    end

endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk
    import fpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       dout_en,
    input logic [7:0] dout,
    input fpm_state_e state,
    input logic       err_bit,
    input logic       commit,
    input logic       wr_stb
);
    p_hiz_unless_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |-> !dout_en);

    p_busy_flag_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PRG_BUSY || state == ST_ERS_BUSY) && dout_en) |-> dout[7]);

    p_error_lands_in_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_bit) |-> (state == ST_WAIT));

    p_commit_then_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == ST_WAIT));

    p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !wr_stb) |=> (state == ST_WAIT));

endmodule

bind fpm_ctrl fpm_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dout_en(dout_en), .dout(dout), .state(seq_state),
    .err_bit(status_byte[6]), .commit(commit_pulse), .wr_stb(wr_stb)
);

// File: tb/tb_fpm_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_ctrl;
    localparam int BUSY = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    event smp_ev;
    bit done = 0;

    always #4 clk = ~clk;

    fpm_ctrl #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // Monitor: pops one expectation per sample event; -1 means bus released.
    initial begin
        forever begin
            @(smp_ev);
            #1;
            begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (e < 0) begin
                    if (dout_en !== 1'b0) begin
                        errors++;
                        $display("FAIL %s: dout_en=%b expected 0", t, dout_en);
                    end
                end else if (dout_en !== 1'b1 || dout !== e[7:0]) begin
                    errors++;
                    $display("FAIL %s: dout_en=%b dout=%h expected en=1 dout=%h",
                             t, dout_en, dout, e[7:0]);
                end
            end
        end
    end

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; addr = a; din = d; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_ce_high(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; addr = a; din = d; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_pins(input logic c, input logic o, input logic w,
                               input logic [17:0] a, input int e, input string t);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; addr = a;
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> smp_ev;
        @(negedge clk);
        oe_n = 1'b1;
    endtask

    task automatic rd(input logic [17:0] a, input int e, input string t);
        expect_pins(1'b0, 1'b0, 1'b1, a, e, t);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state, R2 strobe decode
        rd(18'h00005, 8'hFF, "R1 erased after reset");
        expect_pins(1'b0, 1'b1, 1'b1, 18'h00005, -1, "R2 output disable");
        expect_pins(1'b1, 1'b0, 1'b1, 18'h00005, -1, "R2 chip disable");
        expect_pins(1'b0, 1'b0, 1'b0, 18'h00005, -1, "R2 write strobe low");

        // R5 page program of page 1
        wr(18'h0, 8'h40);
        for (int i = 0; i < 128; i++) wr(18'(128 + i), pat(i));
        rd(18'h00005, 8'h80, "R6 busy status during program");
        wr(18'h0, 8'h20);                      // ignored while busy
        rd(18'h00005, 8'h80, "R6 still busy after stray write");
        repeat (BUSY + 10) @(negedge clk);
        rd(18'h00080, 8'h00, "R4 command wait hides array");
        wr(18'h0, 8'h71); wr(18'h0, 8'h71);
        rd(18'h0, 8'h00, "R8 R6 status clean after program");
        wr(18'h0, 8'h00);
        rd(18'h00080, pat(0),   "R5 offset 0");
        rd(18'h00081, pat(1),   "R3 R5 offset 1 back to back");
        rd(18'h00082, pat(2),   "R5 offset 2");
        rd(18'h000FF, pat(127), "R5 offset 127");
        rd(18'h00005, 8'hFF,    "R5 other page untouched");

        // R9 mismatched erase confirm
        wr(18'h0, 8'h20); wr(18'h0, 8'h21);
        rd(18'h00082, 8'h00, "R9 mismatch leaves command wait");
        wr(18'h0, 8'h71); wr(18'h0, 8'h71);
        rd(18'h0, 8'h40, "R9 error bit after mismatch");
        wr(18'h0, 8'h00);
        rd(18'h00082, pat(2), "R9 array unchanged");

        // R10 page violation
        wr(18'h0, 8'h40);
        wr(18'h00100, 8'hAA);
        wr(18'h00005, 8'hBB);
        wr(18'h0, 8'h71); wr(18'h0, 8'h71);
        rd(18'h0, 8'h40, "R10 error bit after off-page write");
        wr(18'h0, 8'h00);
        rd(18'h00100, 8'hFF, "R10 array unchanged at first address");
        rd(18'h00005, 8'hFF, "R10 array unchanged at second address");

        // R7 erase with R11 chip disable held high throughout
        wr(18'h0, 8'h20); wr(18'h0, 8'h20);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (BUSY + 20) @(negedge clk);
        wr(18'h0, 8'h71); wr(18'h0, 8'h71);
        rd(18'h0, 8'h00, "R11 erase finished while disabled, error cleared");
        wr(18'h0, 8'h00);
        rd(18'h00082, 8'hFF, "R7 programmed byte erased");
        rd(18'h000FF, 8'hFF, "R7 last page byte erased");

        // R12 write with chip enable high is ignored
        wr_ce_high(18'h0, 8'h71);
        rd(18'h00005, 8'hFF, "R12 still in read mode");

        // R13 unknown code
        wr(18'h0, 8'h55);
        rd(18'h00005, 8'h00, "R13 unknown code enters command wait");
        wr(18'h0, 8'h71); wr(18'h0, 8'h71);
        rd(18'h0, 8'h40, "R13 error bit after unknown code");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule